// File: doc/BRIEF.md
# Serial Audio Output Transmitter

This block shifts one stereo pair of 20-bit two's-complement samples onto a single serial data line. It does not generate any clocks. It follows a bit clock and a frame clock that arrive from outside, and it shares them with the receiving path of the same serial port. Both clocks are brought into the system clock domain through synchronisers. Every output bit is launched after a detected falling edge of the bit clock, so a receiver can sample on the rising edge.

A mode input selects the format:
- I2S: the left word is sent while the frame clock is low, and its MSB follows the frame clock transition by one bit clock.
- Right-justified: the left word is sent while the frame clock is high, and the word is placed so that its LSB occupies the last bit slot before the next frame clock edge. The half-frame length used for this placement is measured from the half-frame before.

Software or an upstream datapath writes the next pair into a holding register at any time. The transmitter copies that pair into its working words only when a left half-frame begins. As a result, the left and right samples of one pair always leave in the same frame.

Top module: `aud_ser_tx`

## Requirements
- R1: While `rst_n` is low, `sd_out` is 0.
- R2: `sd_out` changes only within a few system clocks after a falling edge of `bclk`, and it stays constant while `bclk` is high.
- R3: With `fmt_i2s`=1, the half-frame with `lrclk` low carries the left word. The bit slot in which `lrclk` changes is slot 0, and slots 1 to 20 carry word bits 19 down to 0, MSB first.
- R4: With `fmt_i2s`=1, slot 0 and every slot after slot 20 of a half-frame output 0.
- R5: With `fmt_i2s`=0, the half-frame with `lrclk` high carries the left word. For a half-frame of N slots, slot k with k ≥ N−20 carries word bit N−1−k, so bit 0 falls in the last slot before the `lrclk` edge. When N=20, the MSB falls in slot 0.
- R6: With `fmt_i2s`=0, slots 0 to N−21 of a half-frame output 0.
- R7: A pulse on `hold_we` stores `hold_left` and `hold_right`. The stored pair becomes the transmitted pair only at the start of a left half-frame. A write made during a frame changes neither word of that frame, and it appears in full in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | External bit clock |
| lrclk | input | 1 | External frame clock, selects the channel |
| fmt_i2s | input | 1 | 1 selects I2S, 0 selects right-justified |
| hold_we | input | 1 | Write strobe for the holding register |
| hold_left | input | 20 | Next left sample |
| hold_right | input | 20 | Next right sample |
| sd_out | output | 1 | Serial data line |

## Verification
The hardest case to reach is a pair that changes while a frame is already on the line. To reach it, the stimulus pulses the holding-register write between the bit slots of a left half-frame and then checks two things: the right half of that same frame still carries the old right word, and the following frame carries both new words.

A second hard case is right-justified output with exactly 20 slots per half-frame. Here the MSB must go out in the slot where the frame clock changes, which is the same cycle in which the new pair is latched. The vector table covers this case along with 21-slot I2S frames.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;

  localparam int unsigned SAMPLE_W_DEF = 20;
  localparam int unsigned SLOT_W_DEF   = 6;
  localparam int unsigned SYNC_DEPTH   = 2;

  // frame clock level that marks the left channel for the selected format
  function automatic logic left_level(input logic i2s);
    return i2s ? 1'b0 : 1'b1;
  endfunction

endpackage

// File: rtl/aud_tx_sync.sv
module aud_tx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d[0] = d;
    for (int i = 1; i < STAGES; i++) chain_d[i] = chain_q[i-1];
  end

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= 1'b0;
        else        chain_q[g] <= chain_d[g];
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/aud_tx_slot.sv
module aud_tx_slot #(
  parameter int unsigned SLOT_W = 6,
  localparam int unsigned LEN_W = SLOT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_s,
  input  logic              lrclk_s,
  input  logic              left_lvl,
  output logic              tick,
  output logic [SLOT_W-1:0] slot,
  output logic [LEN_W-1:0]  half_len,
  output logic              in_left,
  output logic              left_start
);

  localparam logic [SLOT_W-1:0] SLOT_MAX = '1;

  logic              bclk_q,  bclk_n;
  logic              lrp_q,   lrp_n;
  logic [SLOT_W-1:0] slot_q,  slot_n;
  logic [LEN_W-1:0]  len_q,   len_n;
  logic              tick_q,  tick_n;
  logic              left_q,  left_n;
  logic              lst_q,   lst_n;
  logic              fall;

  assign fall = bclk_q & ~bclk_s;

  always_comb begin
    bclk_n = bclk_s;
    lrp_n  = lrp_q;
    slot_n = slot_q;
    len_n  = len_q;
    left_n = left_q;
    tick_n = fall;
    lst_n  = 1'b0;
    if (fall) begin
      lrp_n = lrclk_s;
      if (lrclk_s != lrp_q) begin
        slot_n = '0;
        len_n  = {1'b0, slot_q} + LEN_W'(1);
        left_n = (lrclk_s == left_lvl);
        lst_n  = (lrclk_s == left_lvl);
      end else if (slot_q != SLOT_MAX) begin
        slot_n = slot_q + SLOT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q <= 1'b0;
      lrp_q  <= 1'b0;
      slot_q <= '0;
      len_q  <= '0;
      tick_q <= 1'b0;
      left_q <= 1'b0;
      lst_q  <= 1'b0;
    end else begin
      bclk_q <= bclk_n;
      lrp_q  <= lrp_n;
      slot_q <= slot_n;
      len_q  <= len_n;
      tick_q <= tick_n;
      left_q <= left_n;
      lst_q  <= lst_n;
    end
  end

  assign tick       = tick_q;
  assign slot       = slot_q;
  assign half_len   = len_q;
  assign in_left    = left_q;
  assign left_start = lst_q;

endmodule

// File: rtl/aud_tx_pair.sv
module aud_tx_pair #(
  parameter int unsigned W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold_we,
  input  logic [W-1:0] hold_l,
  input  logic [W-1:0] hold_r,
  input  logic         take,
  output logic [W-1:0] word_l,
  output logic [W-1:0] word_r,
  output logic [W-1:0] cur_l,
  output logic [W-1:0] cur_r
);

  logic [W-1:0] hl_q, hl_n, hr_q, hr_n;
  logic [W-1:0] cl_q, cl_n, cr_q, cr_n;

  always_comb begin
    hl_n = hl_q;
    hr_n = hr_q;
    cl_n = cl_q;
    cr_n = cr_q;
    if (hold_we) begin
      hl_n = hold_l;
      hr_n = hold_r;
    end
    if (take) begin
      cl_n = hl_q;
      cr_n = hr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hl_q <= '0;
      hr_q <= '0;
      cl_q <= '0;
      cr_q <= '0;
    end else begin
      hl_q <= hl_n;
      hr_q <= hr_n;
      cl_q <= cl_n;
      cr_q <= cr_n;
    end
  end

  // the pair taken at a left start is already visible in that slot
  assign word_l = take ? hl_q : cl_q;
  assign word_r = take ? hr_q : cr_q;
  assign cur_l  = cl_q;
  assign cur_r  = cr_q;

endmodule

// File: rtl/aud_tx_bitsel.sv
module aud_tx_bitsel #(
  parameter int unsigned W      = 20,
  parameter int unsigned SLOT_W = 6,
  localparam int unsigned LEN_W = SLOT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              fmt_i2s,
  input  logic [SLOT_W-1:0] slot,
  input  logic [LEN_W-1:0]  half_len,
  input  logic              in_left,
  input  logic [W-1:0]      word_l,
  input  logic [W-1:0]      word_r,
  output logic              sd
);

  logic [W-1:0]     word;
  logic [LEN_W-1:0] slot_x;
  logic [LEN_W-1:0] i2s_off;
  logic [LEN_W-1:0] rj_off;
  logic             i2s_bit, rj_bit;
  logic             sd_q, sd_n;

  assign word    = in_left ? word_l : word_r;
  assign slot_x  = {1'b0, slot};
  assign i2s_off = LEN_W'(W) - slot_x;
  assign rj_off  = half_len - slot_x - LEN_W'(1);

  always_comb begin
    i2s_bit = 1'b0;
    if (slot_x != '0 && slot_x <= LEN_W'(W)) begin
      for (int k = 0; k < W; k++) if (i2s_off == LEN_W'(k)) i2s_bit = word[k];
    end
  end

  always_comb begin
    rj_bit = 1'b0;
    if (slot_x < half_len) begin
      for (int k = 0; k < W; k++) if (rj_off == LEN_W'(k)) rj_bit = word[k];
    end
  end

  always_comb begin
    sd_n = sd_q;
    if (tick) sd_n = fmt_i2s ? i2s_bit : rj_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sd_q <= 1'b0;
    else        sd_q <= sd_n;
  end

  assign sd = sd_q;

endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx
  import aud_tx_pkg::*;
#(
  parameter int unsigned W      = SAMPLE_W_DEF,
  parameter int unsigned SLOT_W = SLOT_W_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bclk,
  input  logic         lrclk,
  input  logic         fmt_i2s,
  input  logic         hold_we,
  input  logic [W-1:0] hold_left,
  input  logic [W-1:0] hold_right,
  output logic         sd_out
);

  localparam int unsigned LEN_W = SLOT_W + 1;

  logic [1:0]        rst_sync_q;
  logic              rst_i_n;
  logic              bclk_s, lrclk_s;
  logic              tick, in_left, left_start;
  logic [SLOT_W-1:0] slot;
  logic [LEN_W-1:0]  half_len;
  logic [W-1:0]      word_l, word_r, cur_l, cur_r;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  aud_tx_sync #(.STAGES(SYNC_DEPTH)) u_sync_bclk (
    .clk(clk), .rst_n(rst_i_n), .d(bclk), .q(bclk_s)
  );

  aud_tx_sync #(.STAGES(SYNC_DEPTH)) u_sync_lrclk (
    .clk(clk), .rst_n(rst_i_n), .d(lrclk), .q(lrclk_s)
  );

  aud_tx_slot #(.SLOT_W(SLOT_W)) u_slot (
    .clk(clk), .rst_n(rst_i_n), .bclk_s(bclk_s), .lrclk_s(lrclk_s),
    .left_lvl(left_level(fmt_i2s)), .tick(tick), .slot(slot),
    .half_len(half_len), .in_left(in_left), .left_start(left_start)
  );

  aud_tx_pair #(.W(W)) u_pair (
    .clk(clk), .rst_n(rst_i_n), .hold_we(hold_we), .hold_l(hold_left),
    .hold_r(hold_right), .take(tick & left_start), .word_l(word_l),
    .word_r(word_r), .cur_l(cur_l), .cur_r(cur_r)
  );

  aud_tx_bitsel #(.W(W), .SLOT_W(SLOT_W)) u_bitsel (
    .clk(clk), .rst_n(rst_i_n), .tick(tick), .fmt_i2s(fmt_i2s), .slot(slot),
    .half_len(half_len), .in_left(in_left), .word_l(word_l),
    .word_r(word_r), .sd(sd_out)
  );

endmodule

// File: rtl/aud_ser_tx_chk.sv
module aud_ser_tx_chk #(
  parameter int unsigned W      = 20,
  parameter int unsigned SLOT_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fmt_i2s,
  input logic              tick,
  input logic              left_start,
  input logic [SLOT_W-1:0] slot,
  input logic [SLOT_W:0]   half_len,
  input logic [W-1:0]      cur_l,
  input logic [W-1:0]      cur_r,
  input logic              sd_out
);

  // R1
  always @(posedge clk) begin
    if (!rst_n) reset_quiet_chk: assert (sd_out == 1'b0);
  end

  // R2
  line_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sd_out) |-> $past(tick));

  // R4
  i2s_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && fmt_i2s && (slot == '0 || int'(slot) > int'(W))) |=> !sd_out);

  // R6
  rj_lead_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !fmt_i2s && (int'(slot) + int'(W) < int'(half_len))) |=> !sd_out);

  // R7
  pair_left_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(cur_l) || !$stable(cur_r)) |-> $past(tick && left_start));

endmodule

bind aud_ser_tx aud_ser_tx_chk #(.W(W), .SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fmt_i2s(fmt_i2s), .tick(tick),
  .left_start(left_start), .slot(slot), .half_len(half_len),
  .cur_l(cur_l), .cur_r(cur_r), .sd_out(sd_out)
);

// File: tb/test_aud_ser_tx.sv
module test_aud_ser_tx;

  logic        clk;
  logic        rst_n;
  logic        bclk;
  logic        lrclk;
  logic        fmt_i2s;
  logic        hold_we;
  logic [19:0] hold_left;
  logic [19:0] hold_right;
  logic        sd_out;

  int checks;
  int fails;
  bit unstable;

  aud_ser_tx i_aud_ser_tx (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .lrclk(lrclk), .fmt_i2s(fmt_i2s),
    .hold_we(hold_we), .hold_left(hold_left), .hold_right(hold_right),
    .sd_out(sd_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // vector: {fmt_i2s, slots per half, left, right}
  localparam int NV = 6;
  localparam logic [46:0] VEC [NV] = '{
    {1'b1, 6'd32, 20'hA5C3F, 20'h5A3C0},
    {1'b1, 6'd24, 20'h80001, 20'h7FFFE},
    {1'b1, 6'd21, 20'hFFFFF, 20'h00001},
    {1'b0, 6'd32, 20'h12345, 20'hEDCBA},
    {1'b0, 6'd20, 20'h80000, 20'h7FFFF},
    {1'b0, 6'd24, 20'h0F0F0, 20'hF0F0F}
  };

  function automatic logic exp_bit(input logic i2s, input int n, input int s,
                                   input logic [19:0] w);
    if (i2s) return (s >= 1 && s <= 20) ? w[20-s] : 1'b0;
    return (s >= n - 20 && s < n) ? w[n-1-s] : 1'b0;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic write_hold(input logic [19:0] l, input logic [19:0] r);
    hold_left  = l;
    hold_right = r;
    hold_we    = 1'b1;
    @(negedge clk);
    hold_we    = 1'b0;
  endtask

  task automatic do_reset(input logic i2s);
    rst_n   = 1'b0;
    fmt_i2s = i2s;
    bclk    = 1'b1;
    lrclk   = i2s ? 1'b1 : 1'b0;
    repeat (3) @(negedge clk);
    check(sd_out == 1'b0, "R1 reset", 64'(sd_out), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic run_half(input logic lvl, input int n, input logic i2s,
                          input logic [19:0] w, input bit chk, input string tag,
                          input bit wr, input logic [19:0] wl,
                          input logic [19:0] wrr);
    logic [63:0] cap;
    logic [63:0] expv;
    cap  = '0;
    expv = '0;
    for (int s = 0; s < n; s++) begin
      logic v;
      @(negedge clk);
      bclk = 1'b0;
      if (s == 0) lrclk = lvl;
      repeat (6) @(negedge clk);
      v       = sd_out;
      cap[s]  = v;
      expv[s] = exp_bit(i2s, n, s, w);
      bclk = 1'b1;
      for (int h = 0; h < 6; h++) begin
        if (wr && s == 5 && h == 2) write_hold(wl, wrr);
        else @(negedge clk);
        if (sd_out != v) unstable = 1'b1;
      end
    end
    if (chk) check(cap == expv, tag, cap, expv);
  endtask

  task automatic run_frame(input int n, input logic i2s, input logic [19:0] l,
                           input logic [19:0] r, input bit chk, input string tl,
                           input string tr);
    run_half(i2s ? 1'b0 : 1'b1, n, i2s, l, chk, tl, 1'b0, '0, '0);
    run_half(i2s ? 1'b1 : 1'b0, n, i2s, r, chk, tr, 1'b0, '0, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    checks     = 0;
    fails      = 0;
    hold_we    = 1'b0;
    hold_left  = '0;
    hold_right = '0;

    // table walk: R3/R4 for I2S rows, R5/R6 for justified rows, R2 throughout
    for (int i = 0; i < NV; i++) begin
      logic        vi2s;
      int          vn;
      logic [19:0] vl, vr;
      vi2s = VEC[i][46];
      vn   = int'(VEC[i][45:40]);
      vl   = VEC[i][39:20];
      vr   = VEC[i][19:0];
      do_reset(vi2s);
      unstable = 1'b0;
      write_hold(vl, vr);
      run_frame(vn, vi2s, vl, vr, 1'b0, "", "");
      run_frame(vn, vi2s, vl, vr, 1'b0, "", "");
      if (vi2s) run_frame(vn, vi2s, vl, vr, 1'b1, "R3 R4 left", "R3 R4 right");
      else      run_frame(vn, vi2s, vl, vr, 1'b1, "R5 R6 left", "R5 R6 right");
      check(!unstable, "R2 line held while bclk high", 64'(unstable), 64'd0);
    end

    // R7: write in mid left half, frame keeps old pair, next frame has new pair
    do_reset(1'b1);
    write_hold(20'h13579, 20'h2468A);
    run_frame(32, 1'b1, 20'h13579, 20'h2468A, 1'b0, "", "");
    run_frame(32, 1'b1, 20'h13579, 20'h2468A, 1'b1, "R7 pre left", "R7 pre right");
    run_half(1'b0, 32, 1'b1, 20'h13579, 1'b1, "R7 mid-write left", 1'b1,
             20'hCAFE1, 20'hBEEF2);
    run_half(1'b1, 32, 1'b1, 20'h2468A, 1'b1, "R7 same-frame right", 1'b0, '0, '0);
    run_frame(32, 1'b1, 20'hCAFE1, 20'hBEEF2, 1'b1, "R7 next left", "R7 next right");

    // R1: reset in the middle of traffic
    run_half(1'b0, 32, 1'b1, 20'hCAFE1, 1'b0, "", 1'b0, '0, '0);
    do_reset(1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule